// File: doc/BRIEF.md
# Quad SPI Aligned-Burst Read Engine

This block is the host side of a serial flash read path. It fetches 16-byte bursts over a four-bit bidirectional bus using an aligned-word quad read command. Because every burst address is 16-byte aligned, no dummy clocks are needed: the first data clock follows the mode byte directly. A user request carries a 24-bit byte address and a flag that says whether the flash should stay in continuous mode. The block then frames the opcode, address and mode byte, turns the bus around, and returns the sixteen bytes as a stream of one-cycle valid pulses.

When the flash is left in continuous mode, the next burst skips the eight-clock opcode phase. A request with the keep flag cleared sends mode nibble 0, so the transaction after that one sends the opcode again. The controller clock runs at twice the serial clock. Chip select stays high for at least two controller cycles between bursts.

Top module: `qspi_burst_reader`

## Requirements
- R1: A request accepted while `quadEn` is low is refused. `reqErr` pulses for one cycle, the cycle after acceptance, and chip select does not fall.
- R2: A request whose address has any of bits [3:0] set is refused in the same way as R1, with no bus activity.
- R3: When the flash is not in continuous mode, a transaction begins with opcode E3h. It is sent MSB first, one bit per serial clock on io line 0, over 8 serial clocks, and only output enable bit 0 is set.
- R4: The 24-bit address follows on all four lines over 6 serial clocks, bits [23:20] first. All four output enables are set.
- R5: The mode byte follows over 2 serial clocks. Its upper nibble is Ah when `keepCont` was high at acceptance and 0h otherwise. Its lower nibble is 0h. No dummy clock comes after it.
- R6: `contActive` takes the value of `keepCont` in the cycle after a valid request is accepted. The next transaction skips the opcode phase exactly when `contActive` was 1 at acceptance.
- R7: All four output enables are 0 from the first cycle of the first data clock to the end of the transaction.
- R8: The data phase lasts 32 serial clocks. A nibble is sampled at each rising edge, and the first nibble of each pair is the high nibble of the byte. `rdValid` pulses for one cycle per byte with the bytes in address order, giving 16 pulses per burst.
- R9: The bus runs in SPI mode 0. `sclk` is 0 whenever chip select is high, and each serial clock is one controller cycle low followed by one high. Outputs change only as `sclk` falls.
- R10: After a transaction, chip select stays high for at least two controller cycles. `reqReady` is 1 only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, twice the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Burst request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqAddr | input | 24 | Burst byte address; must be 16-byte aligned |
| keepCont | input | 1 | 1: leave the flash in continuous mode after this burst |
| quadEn | input | 1 | Quad mode enabled in the flash configuration |
| reqErr | output | 1 | One-cycle pulse when a request is refused |
| rdValid | output | 1 | One-cycle strobe for each returned byte |
| rdData | output | 8 | Returned byte |
| contActive | output | 1 | 1 when the next burst will skip the opcode |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| ioOut | output | 4 | Values driven onto the four IO lines |
| ioOe | output | 4 | Per-line output enables |
| ioIn | input | 4 | Values read from the four IO lines |

## Verification
The hardest case to reach is a burst whose framing depends on earlier history: it skips the opcode, or sends mode nibble 0 to leave continuous mode, because of a request made one or two bursts before. A refused request placed between two bursts must leave that history untouched. The stimulus therefore runs a fixed chain of requests. The chain enters continuous mode, takes a shortcut burst, places misaligned and quad-disabled requests inside the continuous stretch, exits, and re-enters. Requests are issued back to back so that the minimum chip-select gap is also exercised. A behavioural flash model in the bench tracks its own mode state and returns address-dependent data, so a wrong shortcut decision shows up as wrong bytes as well as wrong pin activity.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  localparam logic [7:0] OPCODE_AWR = 8'hE3;
  localparam logic [3:0] MODE_STAY  = 4'hA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_MOD,
    ST_DAT,
    ST_GAP
  } phase_e;

  typedef struct packed {
    logic       load;
    logic [3:0] modeHi;
    logic       shiftOpc;
    logic       shiftQuad;
    logic       driveSingle;
    logic       driveQuad;
    logic       capture;
  } dpCtl_t;

endpackage

// File: rtl/qbr_ctrl.sv
module qbr_ctrl
  import qbr_pkg::*;
#(
  parameter int AddrW      = 24,
  parameter int BurstBytes = 16,
  parameter int CsGap      = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic [$clog2(BurstBytes)-1:0]     reqAddrLow,
  input  logic                              quadEn,
  input  logic                              keepCont,
  output logic                              reqReady,
  output logic                              reqErr,
  output logic                              csN,
  output logic                              sclk,
  output logic                              contActive,
  output dpCtl_t                            ctl
);

  localparam int OpcClks  = 8;
  localparam int AddrClks = AddrW / 4;
  localparam int ModeClks = 2;
  localparam int DataClks = BurstBytes * 2;
  localparam int CntW     = $clog2(DataClks + 1);
  localparam int GapW     = $clog2(CsGap + 1);

  phase_e         st;
  logic           ph;
  logic [CntW-1:0] cnt;
  logic [GapW-1:0] gapCnt;
  logic           accept;
  logic           badReq;
  logic           lastClk;
  phase_e         nextPhase;

  assign reqReady = (st == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign badReq   = !quadEn || (reqAddrLow != '0);

  always_comb begin
    lastClk   = 1'b0;
    nextPhase = st;
    case (st)
      ST_OPC: begin lastClk = (int'(cnt) == OpcClks - 1);  nextPhase = ST_ADR; end
      ST_ADR: begin lastClk = (int'(cnt) == AddrClks - 1); nextPhase = ST_MOD; end
      ST_MOD: begin lastClk = (int'(cnt) == ModeClks - 1); nextPhase = ST_DAT; end
      ST_DAT: begin lastClk = (int'(cnt) == DataClks - 1); nextPhase = ST_GAP; end
      default: begin lastClk = 1'b0; nextPhase = st; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      ph         <= 1'b0;
      cnt        <= '0;
      gapCnt     <= '0;
      contActive <= 1'b0;
      reqErr     <= 1'b0;
    end else begin
      reqErr <= accept && badReq;
      case (st)
        ST_IDLE: begin
          if (accept && !badReq) begin
            st         <= contActive ? ST_ADR : ST_OPC;
            ph         <= 1'b0;
            cnt        <= '0;
            contActive <= keepCont;
          end
        end
        ST_GAP: begin
          if (int'(gapCnt) == CsGap - 1) begin
            st     <= ST_IDLE;
            gapCnt <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: begin
          ph <= ~ph;
          if (ph) begin
            if (lastClk) begin
              st     <= nextPhase;
              cnt    <= '0;
              gapCnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign csN  = (st == ST_IDLE) || (st == ST_GAP);
  assign sclk = ph;

  always_comb begin
    ctl             = '0;
    ctl.load        = accept && !badReq;
    ctl.modeHi      = keepCont ? MODE_STAY : 4'h0;
    ctl.shiftOpc    = (st == ST_OPC) && ph;
    ctl.shiftQuad   = ((st == ST_ADR) || (st == ST_MOD)) && ph;
    ctl.driveSingle = (st == ST_OPC);
    ctl.driveQuad   = (st == ST_ADR) || (st == ST_MOD);
    ctl.capture     = (st == ST_DAT) && !ph;
  end

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);

  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R1 R2
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> csN);

  // R6
  shortcut_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (st == ($past(contActive) ? ST_ADR : ST_OPC)));

endmodule

// File: rtl/qbr_datapath.sv
module qbr_datapath
  import qbr_pkg::*;
#(
  parameter int AddrW = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [3:0]       ioIn,
  output logic [3:0]       ioOut,
  output logic [3:0]       ioOe,
  output logic             rdValid,
  output logic [7:0]       rdData
);

  localparam int QuadW = AddrW + 8;

  logic [7:0]       opcReg;
  logic [QuadW-1:0] quadReg;
  logic             lowNib;
  logic [3:0]       hiNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcReg  <= '0;
      quadReg <= '0;
    end else if (ctl.load) begin
      opcReg  <= OPCODE_AWR;
      quadReg <= {reqAddr, ctl.modeHi, 4'h0};
    end else begin
      if (ctl.shiftOpc)  opcReg  <= {opcReg[6:0], 1'b0};
      if (ctl.shiftQuad) quadReg <= {quadReg[QuadW-5:0], 4'h0};
    end
  end

  always_comb begin
    ioOut = 4'h0;
    ioOe  = 4'h0;
    if (ctl.driveSingle) begin
      ioOut = {3'b000, opcReg[7]};
      ioOe  = 4'b0001;
    end else if (ctl.driveQuad) begin
      ioOut = quadReg[QuadW-1 -: 4];
      ioOe  = 4'b1111;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowNib  <= 1'b0;
      hiNib   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= 1'b0;
      if (ctl.load) begin
        lowNib <= 1'b0;
      end else if (ctl.capture) begin
        lowNib <= ~lowNib;
        if (lowNib) begin
          rdData  <= {hiNib, ioIn};
          rdValid <= 1'b1;
        end else begin
          hiNib <= ioIn;
        end
      end
    end
  end

  // R7
  bus_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> (ioOe == 4'b0000));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R3 R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000) || (ioOe == 4'b0001) || (ioOe == 4'b1111));

endmodule

// File: rtl/qspi_burst_reader.sv
module qspi_burst_reader
  import qbr_pkg::*;
#(
  parameter int AddrW      = 24,
  parameter int BurstBytes = 16,
  parameter int CsGap      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             keepCont,
  input  logic             quadEn,
  output logic             reqErr,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             contActive,
  output logic             csN,
  output logic             sclk,
  output logic [3:0]       ioOut,
  output logic [3:0]       ioOe,
  input  logic [3:0]       ioIn
);

  localparam int AlignBits = $clog2(BurstBytes);

  dpCtl_t ctl;

  qbr_ctrl #(
    .AddrW(AddrW), .BurstBytes(BurstBytes), .CsGap(CsGap)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqAddrLow(reqAddr[AlignBits-1:0]), .quadEn(quadEn), .keepCont(keepCont),
    .reqReady(reqReady), .reqErr(reqErr), .csN(csN), .sclk(sclk),
    .contActive(contActive), .ctl(ctl)
  );

  qbr_datapath #(
    .AddrW(AddrW)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/sim_qspi_burst_reader.sv
`timescale 1ns/1ps
module sim_qspi_burst_reader;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0;
  logic [23:0] reqAddr  = '0;
  logic        keepCont = 1'b0;
  logic        quadEn   = 1'b1;
  logic        reqReady, reqErr, rdValid, contActive, csN, sclk;
  logic [7:0]  rdData;
  logic [3:0]  ioOut, ioOe;
  logic [3:0]  ioIn = 4'h0;

  qspi_burst_reader u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .keepCont(keepCont), .quadEn(quadEn), .reqErr(reqErr),
    .rdValid(rdValid), .rdData(rdData), .contActive(contActive), .csN(csN),
    .sclk(sclk), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  typedef struct {
    logic cs; logic sck; logic [3:0] oe; logic [3:0] out;
    logic rdv; logic [7:0] rdd; logic rdy; logic err; logic cont;
    string tag;
  } exp_t;

  exp_t q[$];
  logic mCont = 1'b0;

  function automatic logic [7:0] memByte(logic [23:0] a);
    logic [7:0] m;
    m = 8'(a[7:0] * 8'd7);
    return m ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic pushPair(logic [3:0] oe, logic [3:0] out, string tag, logic rdvH, logic [7:0] rddH);
    exp_t e;
    e = '{cs:1'b0, sck:1'b0, oe:oe, out:out, rdv:1'b0, rdd:8'h0, rdy:1'b0, err:1'b0, cont:mCont, tag:tag};
    q.push_back(e);
    e.sck = 1'b1; e.rdv = rdvH; e.rdd = rddH;
    q.push_back(e);
  endtask

  // reference model: builds the expected per-cycle pin trace of one request
  task automatic plan(logic [23:0] a, logic keep, logic qe);
    exp_t e;
    logic useOpc;
    if (!qe || a[3:0] != 4'h0) begin
      e = '{cs:1'b1, sck:1'b0, oe:4'h0, out:4'h0, rdv:1'b0, rdd:8'h0, rdy:1'b1, err:1'b1,
            cont:mCont, tag:(qe ? "R2" : "R1")};
      q.push_back(e);
      return;
    end
    useOpc = !mCont;
    mCont  = keep;
    if (useOpc)
      for (int i = 7; i >= 0; i--) pushPair(4'b0001, {3'b000, 8'hE3 >> i & 8'h1} , "R3", 1'b0, 8'h0);
    for (int n = 5; n >= 0; n--) pushPair(4'hF, a[n*4 +: 4], "R4", 1'b0, 8'h0);
    pushPair(4'hF, keep ? 4'hA : 4'h0, "R5", 1'b0, 8'h0);
    pushPair(4'hF, 4'h0, "R5", 1'b0, 8'h0);
    for (int k = 0; k < 32; k++)
      pushPair(4'h0, 4'h0, "R8", k[0], memByte(a + 24'(k / 2)));
    for (int g = 0; g < 2; g++) begin
      e = '{cs:1'b1, sck:1'b0, oe:4'h0, out:4'h0, rdv:1'b0, rdd:8'h0, rdy:1'b0, err:1'b0,
            cont:mCont, tag:"R10"};
      q.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else e = '{cs:1'b1, sck:1'b0, oe:4'h0, out:4'h0, rdv:1'b0, rdd:8'h0, rdy:1'b1, err:1'b0,
                 cont:mCont, tag:"R10"};
      chk(csN === e.cs, (e.tag == "R1" || e.tag == "R2") ? e.tag : "R10", "csN", 32'(csN), 32'(e.cs));
      chk(sclk === e.sck, "R9", "sclk", 32'(sclk), 32'(e.sck));
      chk(ioOe === e.oe, (e.tag == "R8") ? "R7" : e.tag, "ioOe", 32'(ioOe), 32'(e.oe));
      chk((ioOut & ioOe) === (e.out & e.oe), e.tag, "ioOut", 32'(ioOut & ioOe), 32'(e.out & e.oe));
      chk(rdValid === e.rdv, "R8", "rdValid", 32'(rdValid), 32'(e.rdv));
      if (e.rdv) chk(rdData === e.rdd, "R8", "rdData", 32'(rdData), 32'(e.rdd));
      chk(reqReady === e.rdy, "R10", "reqReady", 32'(reqReady), 32'(e.rdy));
      chk(reqErr === e.err, (e.tag == "R2") ? "R2" : "R1", "reqErr", 32'(reqErr), 32'(e.err));
      chk(contActive === e.cont, "R6", "contActive", 32'(contActive), 32'(e.cont));
      if (reqValid && e.rdy) plan(reqAddr, keepCont, quadEn);
    end
  end

  // behavioural flash: keeps its own continuous-mode state
  int          fRise = 0;
  int          fPre  = 16;
  logic        fCont = 1'b0;
  logic [7:0]  fOpc  = '0;
  logic [23:0] fAddr = '0;
  logic [7:0]  fMode = '0;

  always @(negedge csN) begin
    fRise = 0; fPre = fCont ? 8 : 16; fOpc = '0; fAddr = '0; fMode = '0;
  end

  always @(posedge csN) if (rstN) fCont = (fMode[7:4] == 4'hA);

  always @(posedge sclk) begin
    if (csN === 1'b0) begin
      int r;
      r = fRise + (16 - fPre);
      if (r < 8) fOpc = {fOpc[6:0], ioOut[0]};
      else if (r < 14) fAddr = {fAddr[19:0], ioOut};
      else if (r < 16) fMode = {fMode[3:0], ioOut};
      if (r == 7) chk(fOpc == 8'hE3, "R3", "flash opcode", 32'(fOpc), 32'hE3);
      fRise++;
    end
  end

  always @(negedge sclk) begin
    if (csN === 1'b0 && fRise >= fPre) begin
      int d;
      logic [7:0] b;
      d = fRise - fPre;
      b = memByte(fAddr + 24'(d / 2));
      ioIn = (d % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  task automatic issue(logic [23:0] a, logic keep, logic qe);
    reqAddr = a; keepCont = keep; quadEn = qe; reqValid = 1'b1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN === 1'b1, "R10", "reset csN", 32'(csN), 32'h1);
    chk(sclk === 1'b0, "R9", "reset sclk", 32'(sclk), 32'h0);
    chk(ioOe === 4'h0, "R7", "reset ioOe", 32'(ioOe), 32'h0);
    chk(rdValid === 1'b0, "R8", "reset rdValid", 32'(rdValid), 32'h0);
    chk(contActive === 1'b0, "R6", "reset contActive", 32'(contActive), 32'h0);
    @(posedge clk); #1 rstN = 1'b1;
    issue(24'h000100, 1'b1, 1'b1);  // R3 full opcode, enter continuous
    issue(24'h012340, 1'b1, 1'b1);  // R6 shortcut
    issue(24'h000108, 1'b1, 1'b1);  // R2 misaligned inside continuous stretch
    issue(24'h000200, 1'b1, 1'b0);  // R1 quad disabled
    issue(24'h000200, 1'b0, 1'b1);  // R5 shortcut, exit with nibble 0
    issue(24'hFFFFF0, 1'b0, 1'b1);  // R3 opcode again
    issue(24'hABCDE0, 1'b1, 1'b1);
    issue(24'h000010, 1'b1, 1'b1);
    issue(24'h00000F, 1'b0, 1'b1);  // R2
    issue(24'h5A5A50, 1'b0, 1'b1);
    issue(24'h000030, 1'b0, 1'b1);
    repeat (150) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule